// File: doc/BRIEF.md
# Host Channel Error-Retry Controller

This block decides what happens to one host-side channel of a serial bus controller each time the channel stops during a bulk or control OUT or SETUP transfer. The packet engine reports the stop and its causes as single-cycle pulses: halted, transfer complete, stall, transaction error, NAK and ACK. Cause flags arrive in the same cycle as the halt pulse. On each stop the block picks one outcome. It either releases the channel, or it re-initialises the channel and rewinds the buffer pointer so that the transaction is retried.

The block keeps a transaction-error count, which is 1 at rest. A transaction error that comes with NAK or ACK shows that the device is still responding, so the count goes back to 1 and the transaction is retried. A bare transaction error adds one to the count. When the count reaches the limit, the channel is given up and a failure is reported. A stand-alone ACK also clears the count. The block drives the ACK-interrupt mask as a level and keeps the halt interrupt enabled while a channel is allocated.

Top module: `hchan_retry_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, halt_en_o = 0, ack_mask_o = 0, err_cnt_o = 1 (unsigned binary) and all pulse outputs are 0.
- R2: An alloc_i pulse allocates the channel. From the next cycle halt_en_o = 1, ack_mask_o = 0 and err_cnt_o = 1. Alloc takes precedence over any event in the same cycle.
- R3: A halt with transfer complete or stall gives, in the next cycle, one-cycle pulses on release_o and done_o. It also sets err_cnt_o to 1 and ack_mask_o to 1, and deallocates the channel.
- R4: A halt with transaction error and NAK or ACK (and no complete or stall) sets err_cnt_o to 1 and pulses reinit_o and rewind_o in the next cycle. The channel stays allocated.
- R5: A halt with a transaction error but no NAK, ACK, complete or stall adds 1 to err_cnt_o. If the new count is below ERR_LIMIT (3), reinit_o and rewind_o pulse in the next cycle.
- R6: When that increment brings err_cnt_o to ERR_LIMIT, release_o and failed_o pulse in the next cycle instead, and the channel is deallocated.
- R7: An ACK pulse without halt on an allocated channel sets err_cnt_o to 1 and ack_mask_o to 1, with no action pulse.
- R8: Complete or stall wins over transaction error in the same halt. A halt with none of complete, stall or transaction error produces no action and leaves the count unchanged.
- R9: Events that arrive while no channel is allocated change no output.
- R10: Every action output is a single-cycle pulse. reinit_o and rewind_o always pulse together, and release_o never coincides with reinit_o.
- R11: halt_en_o is 1 exactly while a channel is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | New channel allocation pulse |
| halt_i | input | 1 | Channel halted event |
| xfer_done_i | input | 1 | Transfer complete flag |
| stall_i | input | 1 | Stall response flag |
| xact_err_i | input | 1 | Transaction error flag |
| nak_i | input | 1 | NAK seen flag |
| ack_i | input | 1 | ACK seen event |
| release_o | output | 1 | Release-channel pulse |
| reinit_o | output | 1 | Re-initialise-channel pulse |
| rewind_o | output | 1 | Rewind-buffer-pointer pulse |
| done_o | output | 1 | Release caused by normal completion or stall |
| failed_o | output | 1 | Release caused by the error limit |
| ack_mask_o | output | 1 | ACK interrupt mask level |
| halt_en_o | output | 1 | Halt interrupt enable level |
| err_cnt_o | output | CNT_W | Transaction-error count |

## Verification
The decision logic is driven with runs of bare transaction errors that reach the limit, and with runs where NAK or ACK evidence, or a stand-alone ACK, breaks the run. This separates resetting the count from adding to it, and a retry from a failure. Halts that carry complete or stall together with a transaction error check the priority order. Empty halts and events sent to an unallocated channel show that nothing changes. Reallocation after a failure, after a completion and while a channel is still active shows that the count and the mask start fresh each time.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic [2:0] {
    DEC_NONE,
    DEC_ALLOC,
    DEC_DONE,
    DEC_RETRY_CLR,
    DEC_RETRY_INC,
    DEC_FAIL,
    DEC_ACK
  } dec_e;
endpackage

// File: rtl/hcr_decode.sv
module hcr_decode
  import hcr_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  localparam int CNT_W = $clog2(ERR_LIMIT + 1)
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             alloc_i,
  input  logic             halt_i,
  input  logic             xfer_done_i,
  input  logic             stall_i,
  input  logic             xact_err_i,
  input  logic             nak_i,
  input  logic             ack_i,
  output dec_e             dec_o
);
  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = cnt_i + 1'b1;

  always_comb begin
    dec_o = DEC_NONE;
    if (alloc_i) begin
      dec_o = DEC_ALLOC;
    end else if (active_i) begin
      if (halt_i) begin
        if (xfer_done_i || stall_i) begin
          dec_o = DEC_DONE;
        end else if (xact_err_i) begin
          if (nak_i || ack_i)                          dec_o = DEC_RETRY_CLR;
          else if (cnt_inc == ERR_LIMIT[CNT_W-1:0])    dec_o = DEC_FAIL;
          else                                         dec_o = DEC_RETRY_INC;
        end
      end else if (ack_i) begin
        dec_o = DEC_ACK;
      end
    end
  end
endmodule

// File: rtl/hcr_counter.sv
module hcr_counter
  import hcr_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  localparam int CNT_W = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dec_e             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntRest = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= CntRest;
    end else begin
      unique case (dec_i)
        DEC_ALLOC, DEC_DONE, DEC_RETRY_CLR, DEC_ACK: cnt_o <= CntRest;
        DEC_RETRY_INC, DEC_FAIL:                     cnt_o <= cnt_o + 1'b1;
        default:                                     cnt_o <= cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/hcr_action.sv
module hcr_action
  import hcr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  dec_e dec_i,
  output logic active_o,
  output logic release_o,
  output logic reinit_o,
  output logic rewind_o,
  output logic done_o,
  output logic failed_o,
  output logic ack_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      release_o  <= 1'b0;
      reinit_o   <= 1'b0;
      rewind_o   <= 1'b0;
      done_o     <= 1'b0;
      failed_o   <= 1'b0;
      ack_mask_o <= 1'b0;
    end else begin
      release_o <= (dec_i == DEC_DONE) || (dec_i == DEC_FAIL);
      reinit_o  <= (dec_i == DEC_RETRY_CLR) || (dec_i == DEC_RETRY_INC);
      rewind_o  <= (dec_i == DEC_RETRY_CLR) || (dec_i == DEC_RETRY_INC);
      done_o    <= (dec_i == DEC_DONE);
      failed_o  <= (dec_i == DEC_FAIL);
      unique case (dec_i)
        DEC_ALLOC: begin
          active_o   <= 1'b1;
          ack_mask_o <= 1'b0;
        end
        DEC_DONE: begin
          active_o   <= 1'b0;
          ack_mask_o <= 1'b1;
        end
        DEC_FAIL:  active_o   <= 1'b0;
        DEC_ACK:   ack_mask_o <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hchan_retry_ctrl.sv
module hchan_retry_ctrl
  import hcr_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  localparam int CNT_W = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             halt_i,
  input  logic             xfer_done_i,
  input  logic             stall_i,
  input  logic             xact_err_i,
  input  logic             nak_i,
  input  logic             ack_i,
  output logic             release_o,
  output logic             reinit_o,
  output logic             rewind_o,
  output logic             done_o,
  output logic             failed_o,
  output logic             ack_mask_o,
  output logic             halt_en_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  dec_e             dec;
  logic             active;
  logic [CNT_W-1:0] cnt;

  hcr_decode #(.ERR_LIMIT(ERR_LIMIT)) u_decode (
    .active_i   (active),
    .cnt_i      (cnt),
    .alloc_i    (alloc_i),
    .halt_i     (halt_i),
    .xfer_done_i(xfer_done_i),
    .stall_i    (stall_i),
    .xact_err_i (xact_err_i),
    .nak_i      (nak_i),
    .ack_i      (ack_i),
    .dec_o      (dec)
  );

  hcr_counter #(.ERR_LIMIT(ERR_LIMIT)) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dec_i (dec),
    .cnt_o (cnt)
  );

  hcr_action u_action (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (dec),
    .active_o  (active),
    .release_o (release_o),
    .reinit_o  (reinit_o),
    .rewind_o  (rewind_o),
    .done_o    (done_o),
    .failed_o  (failed_o),
    .ack_mask_o(ack_mask_o)
  );

  assign halt_en_o = active;
  assign err_cnt_o = cnt;
endmodule

// File: rtl/hchan_retry_chk.sv
module hchan_retry_chk #(
  parameter int ERR_LIMIT = 3,
  localparam int CNT_W = $clog2(ERR_LIMIT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_i,
  input logic             halt_i,
  input logic             xfer_done_i,
  input logic             stall_i,
  input logic             xact_err_i,
  input logic             nak_i,
  input logic             ack_i,
  input logic             release_o,
  input logic             reinit_o,
  input logic             rewind_o,
  input logic             done_o,
  input logic             failed_o,
  input logic             ack_mask_o,
  input logic             halt_en_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  logic bare_err;
  assign bare_err = halt_i && xact_err_i && !xfer_done_i && !stall_i && !nak_i && !ack_i;

  a_r2_alloc_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (halt_en_o && !ack_mask_o && err_cnt_o == CNT_W'(1)));

  a_r3_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_en_o && !alloc_i && halt_i && (xfer_done_i || stall_i))
      |=> (release_o && done_o && ack_mask_o && !halt_en_o));

  a_r5_bare_err_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_en_o && !alloc_i && bare_err) |=> (err_cnt_o == $past(err_cnt_o) + 1'b1));

  a_r6_fail_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_o |-> (release_o && err_cnt_o == CNT_W'(ERR_LIMIT) && !halt_en_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_en_o && !alloc_i) |=> (!release_o && !reinit_o && $stable(err_cnt_o)
                                  && $stable(ack_mask_o)));

  a_r10_pulse_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reinit_o == rewind_o) && $onehot0({release_o, reinit_o})
      && (!done_o || release_o) && !(done_o && failed_o));

  a_r10_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !release_o);

  a_r11_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> !halt_en_o);
endmodule

bind hchan_retry_ctrl hchan_retry_chk #(.ERR_LIMIT(ERR_LIMIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alloc_i    (alloc_i),
  .halt_i     (halt_i),
  .xfer_done_i(xfer_done_i),
  .stall_i    (stall_i),
  .xact_err_i (xact_err_i),
  .nak_i      (nak_i),
  .ack_i      (ack_i),
  .release_o  (release_o),
  .reinit_o   (reinit_o),
  .rewind_o   (rewind_o),
  .done_o     (done_o),
  .failed_o   (failed_o),
  .ack_mask_o (ack_mask_o),
  .halt_en_o  (halt_en_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/hchan_retry_ctrl_test.sv
module hchan_retry_ctrl_test;
  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_i = 0, halt_i = 0, xfer_done_i = 0, stall_i = 0;
  logic xact_err_i = 0, nak_i = 0, ack_i = 0;
  logic release_o, reinit_o, rewind_o, done_o, failed_o, ack_mask_o, halt_en_o;
  logic [1:0] err_cnt_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  hchan_retry_ctrl #(.ERR_LIMIT(LIMIT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_i(alloc_i), .halt_i(halt_i),
    .xfer_done_i(xfer_done_i), .stall_i(stall_i), .xact_err_i(xact_err_i),
    .nak_i(nak_i), .ack_i(ack_i), .release_o(release_o), .reinit_o(reinit_o),
    .rewind_o(rewind_o), .done_o(done_o), .failed_o(failed_o),
    .ack_mask_o(ack_mask_o), .halt_en_o(halt_en_o), .err_cnt_o(err_cnt_o)
  );

  // behavioural reference
  bit m_act, m_mask, m_rel, m_ri, m_rw, m_dn, m_fl;
  int m_cnt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_mask = 0; m_cnt = 1;
      m_rel = 0; m_ri = 0; m_rw = 0; m_dn = 0; m_fl = 0;
    end else begin
      m_rel = 0; m_ri = 0; m_rw = 0; m_dn = 0; m_fl = 0;
      if (alloc_i) begin
        m_act = 1; m_cnt = 1; m_mask = 0;
      end else if (m_act) begin
        if (halt_i) begin
          if (xfer_done_i || stall_i) begin
            m_cnt = 1; m_mask = 1; m_rel = 1; m_dn = 1; m_act = 0;
          end else if (xact_err_i) begin
            if (nak_i || ack_i) begin
              m_cnt = 1; m_ri = 1; m_rw = 1;
            end else begin
              m_cnt = m_cnt + 1;
              if (m_cnt == LIMIT) begin
                m_rel = 1; m_fl = 1; m_act = 0;
              end else begin
                m_ri = 1; m_rw = 1;
              end
            end
          end
        end else if (ack_i) begin
          m_cnt = 1; m_mask = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [8:0] got, exp;
    got = {release_o, reinit_o, rewind_o, done_o, failed_o, ack_mask_o, halt_en_o, err_cnt_o};
    exp = {m_rel, m_ri, m_rw, m_dn, m_fl, m_mask, m_act, m_cnt[1:0]};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs got %b expected %b at %0t", cur_req, got, exp, $time);
    end
    checks++;
    if (release_o && reinit_o) begin
      errors++;
      $display("FAIL R10: release and reinit together got 1 expected 0 at %0t", $time);
    end
  end

  task automatic ev(input string r, input bit a, h, d, s, x, n, k);
    cur_req = r;
    alloc_i = a; halt_i = h; xfer_done_i = d; stall_i = s;
    xact_err_i = x; nak_i = n; ack_i = k;
    @(negedge clk);
    alloc_i = 0; halt_i = 0; xfer_done_i = 0; stall_i = 0;
    xact_err_i = 0; nak_i = 0; ack_i = 0;
    @(negedge clk);
  endtask

  task automatic expect_cnt(input string r, input int want);
    checks++;
    if (int'(err_cnt_o) != want) begin
      errors++;
      $display("FAIL %s: err_cnt got %0d expected %0d", r, err_cnt_o, want);
    end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rst_ni = 1'b1;
    @(negedge clk);
    expect_cnt("R1", 1);
    // R9: idle events
    ev("R9", 0, 1, 1, 0, 0, 0, 0);
    ev("R9", 0, 1, 0, 0, 1, 0, 0);
    ev("R9", 0, 0, 0, 0, 0, 0, 1);
    expect_cnt("R9", 1);
    // R5 / R6: bare errors to the limit
    ev("R2", 1, 0, 0, 0, 0, 0, 0);
    ev("R5", 0, 1, 0, 0, 1, 0, 0);
    expect_cnt("R5", 2);
    ev("R6", 0, 1, 0, 0, 1, 0, 0);
    expect_cnt("R6", 3);
    ev("R9", 0, 1, 0, 0, 1, 0, 0);
    // R4: evidence resets count
    ev("R2", 1, 0, 0, 0, 0, 0, 0);
    expect_cnt("R2", 1);
    ev("R5", 0, 1, 0, 0, 1, 0, 0);
    ev("R4", 0, 1, 0, 0, 1, 1, 0);
    expect_cnt("R4", 1);
    ev("R5", 0, 1, 0, 0, 1, 0, 0);
    ev("R4", 0, 1, 0, 0, 1, 0, 1);
    expect_cnt("R4", 1);
    // R7: stand-alone ack
    ev("R5", 0, 1, 0, 0, 1, 0, 0);
    ev("R7", 0, 0, 0, 0, 0, 0, 1);
    expect_cnt("R7", 1);
    // R8: empty halt, then priority
    ev("R5", 0, 1, 0, 0, 1, 0, 0);
    ev("R8", 0, 1, 0, 0, 0, 0, 1);
    expect_cnt("R8", 2);
    ev("R8", 0, 1, 0, 1, 1, 0, 0);
    expect_cnt("R3", 1);
    // R2: realloc clears mask, alloc beats halt
    ev("R2", 1, 1, 1, 0, 0, 0, 0);
    ev("R5", 0, 1, 0, 0, 1, 0, 0);
    ev("R2", 1, 0, 0, 0, 0, 0, 0);
    expect_cnt("R2", 1);
    ev("R3", 0, 1, 1, 0, 1, 0, 0);
    ev("R11", 0, 1, 0, 0, 1, 0, 0);
    // back-to-back bare errors
    ev("R2", 1, 0, 0, 0, 0, 0, 0);
    cur_req = "R10";
    halt_i = 1; xact_err_i = 1;
    @(negedge clk);
    @(negedge clk);
    halt_i = 0; xact_err_i = 0;
    repeat (3) @(negedge clk);
    expect_cnt("R6", 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule